// File: doc/BRIEF.md
# Stream-to-Memory Ingress Controller

This block is the write-side front end of a simple stream-to-memory mover. Beats arrive on an AXI4-Stream slave port (data, valid, last, with ready driven by the block) and are held in a four-beat buffer. A control port programs a transfer: a base address, a length in bytes, and a start strobe. While a transfer runs, the block drains one buffered beat per cycle onto a plain memory-write port. Each write carries an address that steps up from the base. A 2-bit status output reports idle, busy, done or error.

The stream side is decoupled from programming, and the buffer behaviour follows from that. Out of reset the block already accepts beats, up to the buffer depth. The first start after a reset flushes whatever was buffered. When a transfer ends, the buffer refills. A start issued from the done state keeps the refilled beats, and they become the head of the new transfer.

Each transfer must be closed by tlast on or before the beat that uses up the programmed byte count. If the count runs out on a beat without tlast, the block enters a sticky error state. In that state it refuses all input until a hard or soft reset.

Top module: `s2m_ingress`

## Requirements
- R1: During and right after reset, s_tready is 1, status is 0 (idle) and mem_we is 0.
- R2: Before any start, exactly 4 beats are accepted while s_tvalid is held high. s_tready is then 0 and stays 0.
- R3: A start in the idle state (status 0) empties the buffer, including any beat offered in that same cycle. The next cycle shows status 1 (busy) with no memory write.
- R4: A beat is taken only on an edge where both s_tvalid and s_tready are 1. Memory writes happen only while status is 1 (busy), at most one per cycle, in arrival order.
- R5: The k-th write of a transfer (k counted from 0) carries address base + 4*k and the data of the corresponding beat.
- R6: Writing a beat with tlast ends the transfer with status 2 (done), even if programmed bytes remain.
- R7: In the done state, beats are still accepted until the buffer holds 4. A start from the done state keeps those beats and writes them first.
- R8: A start while status is 1 (busy) is ignored. Base and length are not reloaded.
- R9: Writing a beat without tlast when 4 or fewer programmed bytes remain sets status 3 (error). Error is sticky: s_tready stays 0, no writes occur, and start is ignored.
- R10: ctl_soft_rst returns the block to status 0 (idle) with an empty buffer and s_tready 1. This also clears the error state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_tdata | input | 32 | Stream beat data |
| s_tvalid | input | 1 | Stream beat valid |
| s_tlast | input | 1 | Final beat of a packet |
| s_tready | output | 1 | Block can take a beat |
| ctl_start | input | 1 | Start strobe for a transfer |
| ctl_base | input | 32 | Base byte address of the transfer |
| ctl_len_bytes | input | 16 | Transfer length in bytes |
| ctl_soft_rst | input | 1 | Soft reset: flush and return to idle |
| status | output | 2 | 0 idle, 1 busy, 2 done, 3 error |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 32 | Memory write byte address |
| mem_data | output | 32 | Memory write data |

## Verification
A table of eight beats is streamed in one pass. The first four, closed by tlast, must land at the first base. The next four arrive after completion and must be held back, then written at a second base after a start from the done state; this separates a block that keeps refilled beats from one that flushes on every start. Before any programming, a held-high valid separates a buffer capped at four beats from one that keeps accepting. A start pulse in the middle of a transfer shows whether the running addresses are reloaded. An early tlast and a count that runs out without tlast separate normal completion from the sticky error. A soft reset followed by another held-high valid shows that the buffer came back empty.

// File: rtl/s2m_pkg.sv
package s2m_pkg;
    localparam int DATA_W     = 32;
    localparam int BEAT_BYTES = DATA_W / 8;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUSY = 2'd1,
        ST_DONE = 2'd2,
        ST_ERR  = 2'd3
    } s2m_state_e;

    typedef struct packed {
        logic              last;
        logic [DATA_W-1:0] data;
    } s2m_beat_t;

    // true when the remaining byte budget is used up by one more beat
    function automatic logic budget_spent(input logic [31:0] remain);
        return remain <= 32'(BEAT_BYTES);
    endfunction
endpackage

// File: rtl/s2m_fifo.sv
module s2m_fifo
    import s2m_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      flush,
    input  logic      push,
    input  s2m_beat_t push_beat,
    input  logic      pop,
    output s2m_beat_t head,
    output logic      empty,
    output logic      full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);

    s2m_beat_t        slots [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] fill;

    assign empty = (fill == '0);
    assign full  = (fill == CNT_W'(DEPTH));
    assign head  = slots[rd_ptr];

    wire do_push = push && !full;
    wire do_pop  = pop && !empty;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (do_push) begin
                slots[wr_ptr] <= push_beat;
                wr_ptr <= (wr_ptr == LAST_IDX) ? '0 : wr_ptr + 1'b1;
            end
            if (do_pop)
                rd_ptr <= (rd_ptr == LAST_IDX) ? '0 : rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   fill <= fill + 1'b1;
                2'b01:   fill <= fill - 1'b1;
                default: fill <= fill;
            endcase
        end
    end
endmodule

// File: rtl/s2m_xfer_ctl.sv
module s2m_xfer_ctl
    import s2m_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              soft_rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] base,
    input  logic [LEN_W-1:0]  len_bytes,
    input  logic              beat_avail,
    input  logic              beat_last,
    output s2m_state_e        state,
    output logic              flush,
    output logic              pop,
    output logic [ADDR_W-1:0] addr
);
    logic [LEN_W-1:0] remain;

    assign pop   = (state == ST_BUSY) && beat_avail;
    // only the first programming after a reset clears the buffer
    assign flush = soft_rst || (start && state == ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            state  <= ST_IDLE;
            remain <= '0;
            addr   <= '0;
        end else begin
            case (state)
                ST_IDLE, ST_DONE: begin
                    if (start) begin
                        state  <= ST_BUSY;
                        addr   <= base;
                        remain <= len_bytes;
                    end
                end
                ST_BUSY: begin
                    if (pop) begin
                        addr <= addr + ADDR_W'(BEAT_BYTES);
                        if (beat_last)
                            state <= ST_DONE;
                        else if (budget_spent(32'(remain)))
                            state <= ST_ERR;
                        else
                            remain <= remain - LEN_W'(BEAT_BYTES);
                    end
                end
                default: state <= ST_ERR;
            endcase
        end
    end
endmodule

// File: rtl/s2m_ingress.sv
module s2m_ingress
    import s2m_pkg::*;
#(
    parameter int DEPTH  = 4,
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] s_tdata,
    input  logic              s_tvalid,
    input  logic              s_tlast,
    output logic              s_tready,
    input  logic              ctl_start,
    input  logic [ADDR_W-1:0] ctl_base,
    input  logic [LEN_W-1:0]  ctl_len_bytes,
    input  logic              ctl_soft_rst,
    output logic [1:0]        status,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_data
);
    s2m_beat_t  in_beat, head;
    logic       empty, full, flush, pop;
    s2m_state_e state;

    assign in_beat  = '{last: s_tlast, data: s_tdata};
    assign s_tready = !full && (state != ST_ERR);

    s2m_fifo #(.DEPTH(DEPTH)) u_buf (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush),
        .push      (s_tvalid && s_tready),
        .push_beat (in_beat),
        .pop       (pop),
        .head      (head),
        .empty     (empty),
        .full      (full)
    );

    s2m_xfer_ctl #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_ctl (
        .clk        (clk),
        .rst        (rst),
        .soft_rst   (ctl_soft_rst),
        .start      (ctl_start),
        .base       (ctl_base),
        .len_bytes  (ctl_len_bytes),
        .beat_avail (!empty),
        .beat_last  (head.last),
        .state      (state),
        .flush      (flush),
        .pop        (pop),
        .addr       (mem_addr)
    );

    assign status   = state;
    assign mem_we   = pop;
    assign mem_data = head.data;
endmodule

// File: rtl/s2m_ingress_chk.sv
module s2m_ingress_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              soft_rst,
    input logic              s_tready,
    input logic [1:0]        status,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr
);
    p_ready_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (s_tready && status == 2'd0));

    p_write_only_busy_r4: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> status == 2'd1);

    p_addr_step_r5: assert property (@(posedge clk) disable iff (rst)
        (mem_we && $past(mem_we) && $past(status) == 2'd1 && status == 2'd1)
        |-> mem_addr == $past(mem_addr) + ADDR_W'(4));

    p_err_blocks_r9: assert property (@(posedge clk) disable iff (rst)
        status == 2'd3 |-> (!s_tready && !mem_we));

    p_err_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (status == 2'd3 && !soft_rst) |=> status == 2'd3);

    p_soft_rst_idle_r10: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> (status == 2'd0 && s_tready));
endmodule

bind s2m_ingress s2m_ingress_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .soft_rst (ctl_soft_rst),
    .s_tready (s_tready),
    .status   (status),
    .mem_we   (mem_we),
    .mem_addr (mem_addr)
);

// File: tb/s2m_ingress_bench.sv
module s2m_ingress_bench;
    localparam time CLK_P = 8ns;

    logic        clk = 0, rst = 1;
    logic [31:0] s_tdata = '0;
    logic        s_tvalid = 0, s_tlast = 0, ctl_start = 0, ctl_soft_rst = 0;
    logic [31:0] ctl_base = '0;
    logic [15:0] ctl_len_bytes = '0;
    logic        s_tready, mem_we;
    logic [1:0]  status;
    logic [31:0] mem_addr, mem_data;

    int checks = 0, fails = 0, nlog = 0;
    logic [31:0] log_addr [64];
    logic [31:0] log_data [64];

    // {last, data}: four beats of one packet, then four that arrive after it
    localparam logic [32:0] VEC [8] = '{
        {1'b0, 32'hA000_0001}, {1'b0, 32'hA000_0002},
        {1'b0, 32'hA000_0003}, {1'b1, 32'hA000_0004},
        {1'b0, 32'hB000_0001}, {1'b0, 32'hB000_0002},
        {1'b0, 32'hB000_0003}, {1'b1, 32'hB000_0004}
    };

    s2m_ingress u_s2m_ingress (
        .clk(clk), .rst(rst), .s_tdata(s_tdata), .s_tvalid(s_tvalid),
        .s_tlast(s_tlast), .s_tready(s_tready), .ctl_start(ctl_start),
        .ctl_base(ctl_base), .ctl_len_bytes(ctl_len_bytes),
        .ctl_soft_rst(ctl_soft_rst), .status(status), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_data(mem_data)
    );

    always #(CLK_P/2) clk = ~clk;

    always @(negedge clk) begin
        if (!rst && mem_we && nlog < 64) begin
            log_addr[nlog] = mem_addr;
            log_data[nlog] = mem_data;
            nlog++;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send(input logic [31:0] d, input logic l);
        int w = 0;
        @(negedge clk);
        s_tvalid = 1; s_tdata = d; s_tlast = l;
        #1;
        while (!s_tready && w < 50) begin
            @(negedge clk); #1; w++;
        end
        check(w < 50, "R4", "beat never accepted", 32'(w), 32'd0);
        @(posedge clk); #1;
        s_tvalid = 0; s_tlast = 0;
    endtask

    task automatic program_xfer(input logic [31:0] base, input logic [15:0] len);
        @(negedge clk);
        ctl_start = 1; ctl_base = base; ctl_len_bytes = len;
        @(negedge clk);
        ctl_start = 0;
    endtask

    // holds valid for n cycles, returns how many beats were taken
    task automatic hold_valid(input int n, output int taken);
        taken = 0;
        @(negedge clk);
        s_tvalid = 1; s_tdata = 32'hDEAD_0000; s_tlast = 0;
        for (int i = 0; i < n; i++) begin
            #1;
            if (s_tready) taken++;
            @(negedge clk);
            s_tdata = s_tdata + 1;
        end
        s_tvalid = 0;
    endtask

    task automatic check_writes(input int first, input int cnt, input logic [31:0] base,
                                input int vec0, input string req);
        for (int k = 0; k < cnt; k++) begin
            check(log_addr[first+k] == base + 32'(4*k), req, "write address",
                  log_addr[first+k], base + 32'(4*k));
            check(log_data[first+k] == VEC[vec0+k][31:0], req, "write data",
                  log_data[first+k], VEC[vec0+k][31:0]);
        end
    endtask

    initial begin
        #(CLK_P * 100000);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        int taken;
        tick(3);
        #1;
        check(s_tready == 1, "R1", "tready in reset", 32'(s_tready), 32'd1);
        rst = 0;
        tick(1); #1;
        check(s_tready == 1, "R1", "tready after reset", 32'(s_tready), 32'd1);
        check(status == 2'd0, "R1", "status after reset", 32'(status), 32'd0);
        check(mem_we == 0, "R1", "mem_we after reset", 32'(mem_we), 32'd0);

        // R2 / R4: unprogrammed block takes exactly four beats
        hold_valid(8, taken);
        #1;
        check(taken == 4, "R2", "beats taken unprogrammed", 32'(taken), 32'd4);
        check(s_tready == 0, "R2", "tready once buffer full", 32'(s_tready), 32'd0);
        check(nlog == 0, "R4", "writes while idle", 32'(nlog), 32'd0);

        // R3: first start flushes the four stale beats
        program_xfer(32'h100, 16'd16);
        #1;
        check(status == 2'd1, "R3", "status after start", 32'(status), 32'd1);
        check(s_tready == 1, "R3", "tready after flush", 32'(s_tready), 32'd1);
        check(mem_we == 0, "R3", "write of flushed beat", 32'(mem_we), 32'd0);

        // table walk: packet A then four refill beats
        for (int i = 0; i < 8; i++) send(VEC[i][31:0], VEC[i][32]);
        tick(3); #1;
        check(nlog == 4, "R6", "writes of first packet", 32'(nlog), 32'd4);
        check_writes(0, 4, 32'h100, 0, "R5");
        check(status == 2'd2, "R6", "status after tlast", 32'(status), 32'd2);
        check(s_tready == 0, "R7", "tready with refill full", 32'(s_tready), 32'd0);

        // R7: start from done keeps the refilled beats
        program_xfer(32'h200, 16'd16);
        tick(6); #1;
        check(nlog == 8, "R7", "writes of kept beats", 32'(nlog), 32'd8);
        check_writes(4, 4, 32'h200, 4, "R7");
        check(status == 2'd2, "R7", "status after kept packet", 32'(status), 32'd2);

        // R8: start while busy is ignored
        program_xfer(32'h300, 16'd16);
        send(32'hC000_0000, 0);
        program_xfer(32'h900, 16'd4);
        send(32'hC000_0001, 0);
        send(32'hC000_0002, 0);
        send(32'hC000_0003, 1);
        tick(4); #1;
        check(nlog == 12, "R8", "writes of third packet", 32'(nlog), 32'd12);
        for (int k = 0; k < 4; k++)
            check(log_addr[8+k] == 32'h300 + 32'(4*k), "R8", "address not reloaded",
                  log_addr[8+k], 32'h300 + 32'(4*k));
        check(status == 2'd2, "R8", "status not errored", 32'(status), 32'd2);

        // R6: early tlast completes before the byte count
        program_xfer(32'h400, 16'd32);
        send(32'hD000_0000, 0);
        send(32'hD000_0001, 1);
        tick(4); #1;
        check(nlog == 14, "R6", "writes of short packet", 32'(nlog), 32'd14);
        check(log_addr[13] == 32'h404 && log_data[13] == 32'hD000_0001, "R6",
              "last short write", log_addr[13], 32'h404);
        check(status == 2'd2, "R6", "status after early tlast", 32'(status), 32'd2);

        // R9: count runs out without tlast
        program_xfer(32'h500, 16'd8);
        send(32'hE000_0000, 0);
        send(32'hE000_0001, 0);
        send(32'hE000_0002, 0);
        tick(2); #1;
        check(status == 2'd3, "R9", "status after overrun", 32'(status), 32'd3);
        check(s_tready == 0, "R9", "tready in error", 32'(s_tready), 32'd0);
        check(nlog == 16, "R9", "writes before error", 32'(nlog), 32'd16);
        check(log_addr[15] == 32'h504, "R9", "second write address", log_addr[15], 32'h504);
        hold_valid(4, taken);
        check(taken == 0, "R9", "beats taken in error", 32'(taken), 32'd0);
        program_xfer(32'h600, 16'd64);
        tick(2); #1;
        check(status == 2'd3, "R9", "start in error", 32'(status), 32'd3);
        check(nlog == 16, "R9", "writes in error", 32'(nlog), 32'd16);

        // R10: soft reset clears error and empties the buffer
        @(negedge clk); ctl_soft_rst = 1;
        @(negedge clk); ctl_soft_rst = 0;
        #1;
        check(status == 2'd0, "R10", "status after soft reset", 32'(status), 32'd0);
        check(s_tready == 1, "R10", "tready after soft reset", 32'(s_tready), 32'd1);
        hold_valid(6, taken);
        check(taken == 4, "R10", "buffer empty after soft reset", 32'(taken), 32'd4);

        summary();
        $finish;
    end
endmodule